// File: doc/BRIEF.md
# Constant Off-Time Chopper Controller

This block is the digital sequencer for one H-bridge phase of a bipolar motor driver. It holds the peak winding current by chopping: while the bridge drives the winding, the current rises until an external comparator reports that the sense voltage has passed the reference. The controller then starts a fixed off period. During that period the winding current recirculates, and afterwards the bridge drives again. The comparator, the sense resistor and the power switches sit outside the block. The controller sees only a one-bit comparator result and produces four gate commands, one for each switch: the high and low switch of leg A and of leg B.

Every drive period begins with a blanking window. During this window the comparator is masked, so the recovery spike at turn-on cannot end the drive period early. Each move between conducting patterns passes through a dead-time window with all switches off. The off period recirculates the current in one of two ways, picked by a mode input. In fast decay the opposite diagonal is driven. In slow decay both low switches are driven. An enable input and a fault input each force every switch off at once. A fault also asserts a pull-down output meant for an open-drain enable line. All three interval lengths are parameters given in clock cycles.

Top module: `offtime_chopper`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all four gate outputs are 0, whatever the other inputs do.
- R2: From idle, with `enIn`=1 and `faultIn`=0 at a clock edge, the gates stay 0 for one idle cycle plus DEAD_CYC dead cycles. After that the drive pattern appears.
- R3: The drive pattern depends on `dirIn` as captured at the last edge before drive starts. `dirIn`=0 drives `aHi` and `bLo`. `dirIn`=1 drives `bHi` and `aLo`. A change of `dirIn` during drive has no effect until the next drive period.
- R4: For the first BLANK_CYC cycles of every drive period, `cmpHi` is ignored, so a drive period lasts at least BLANK_CYC cycles.
- R5: Once blanking is over, `cmpHi`=1 at a clock edge ends the drive period, and the off period starts in the next cycle.
- R6: The off period lasts OFF_CYC cycles. Its first DEAD_CYC cycles have all gates 0. After it, DEAD_CYC more all-off cycles follow, and then drive resumes. The total gap is OFF_CYC+DEAD_CYC cycles.
- R7: In fast decay (`slowDecay`=0), the recirculation part of the off period drives the diagonal opposite to the one used for drive.
- R8: In slow decay (`slowDecay`=1), the recirculation part drives `aLo` and `bLo` only.
- R9: `enIn`=0 forces all gates to 0 in the same cycle. The controller returns to idle, and it restarts as in R2.
- R10: `faultIn`=1 forces all gates to 0 in the same cycle, holds `enPullDown` at 1 for as long as the fault lasts, and returns the controller to idle.
- R11: No leg ever has its high and low switch on together. A switch turns on only after a cycle in which both switches of its leg were off.
- R12: `slowDecay` is captured at the edge that ends drive. A change during the off period does not alter the recirculation pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enIn | input | 1 | Bridge enable, active high |
| faultIn | input | 1 | Overcurrent or overtemperature fault, active high |
| cmpHi | input | 1 | Comparator result: 1 when the sense voltage is above the reference |
| slowDecay | input | 1 | Decay select: 1 slow, 0 fast |
| dirIn | input | 1 | Drive direction select |
| aHi | output | 1 | Leg A high-side gate command |
| aLo | output | 1 | Leg A low-side gate command |
| bHi | output | 1 | Leg B high-side gate command |
| bLo | output | 1 | Leg B low-side gate command |
| enPullDown | output | 1 | Pull-down request for the enable line |

## Verification
Gate outputs are decoded from registered state. A change in `cmpHi`, `dirIn` or `slowDecay` therefore shows at the gates no earlier than the cycle after the edge that samples it. `enIn` and `faultIn` act within the same cycle. The bench drives inputs just after the falling edge and keeps a timed model that advances on each rising edge. It compares all four gates against that model at every falling edge, so one-cycle errors in the dead, blanking or off windows show up as mismatches. Enable and fault shutdown are also checked a fraction of a cycle after the input moves, before any clock edge.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DEADON,
    ST_DRIVE,
    ST_OFF
  } chopState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDead;
    logic loadBlank;
    logic loadOff;
    logic latchDir;
    logic latchMode;
  } chopStrobe_t;

  // gate vector order: {aHi, aLo, bHi, bLo}
  localparam logic [3:0] PAT_NONE  = 4'b0000;
  localparam logic [3:0] PAT_DIAG0 = 4'b1001;
  localparam logic [3:0] PAT_DIAG1 = 4'b0110;
  localparam logic [3:0] PAT_LOWS  = 4'b0101;

endpackage

// File: rtl/chop_datapath.sv
module chop_datapath
  import chop_pkg::*;
#(
  parameter int unsigned DEAD_CYC  = 20,
  parameter int unsigned BLANK_CYC = 200,
  parameter int unsigned OFF_CYC   = 2000
) (
  input  logic        clk,
  input  logic        rst,
  input  chopStrobe_t stb,
  input  logic        dirIn,
  input  logic        slowIn,
  output logic        cntZero,
  output logic        leadDead,
  output logic        dirHeld,
  output logic        slowHeld
);
  localparam int unsigned MAX_AB = (BLANK_CYC > DEAD_CYC) ? BLANK_CYC : DEAD_CYC;
  localparam int unsigned MAX_C  = (OFF_CYC > MAX_AB) ? OFF_CYC : MAX_AB;
  localparam int unsigned CW     = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] LD_DEAD  = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] LD_BLANK = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] LD_OFF   = CW'(OFF_CYC - 1);
  localparam logic [CW-1:0] LEAD_TH  = CW'(OFF_CYC - DEAD_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (stb.loadDead) begin
      cnt <= LD_DEAD;
    end else if (stb.loadBlank) begin
      cnt <= LD_BLANK;
    end else if (stb.loadOff) begin
      cnt <= LD_OFF;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dirHeld  <= 1'b0;
      slowHeld <= 1'b0;
    end else begin
      if (stb.latchDir)  dirHeld  <= dirIn;
      if (stb.latchMode) slowHeld <= slowIn;
    end
  end

  assign cntZero  = (cnt == '0);
  // true during the first DEAD_CYC cycles of the off one-shot
  assign leadDead = (cnt >= LEAD_TH);

endmodule

// File: rtl/chop_control.sv
module chop_control
  import chop_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        act,
  input  logic        cmpHi,
  input  logic        cntZero,
  input  logic        leadDead,
  input  logic        dirHeld,
  input  logic        slowHeld,
  output chopStrobe_t stb,
  output logic [3:0]  pattern
);
  chopState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    if (!act) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          nextState    = ST_DEADON;
          stb.loadDead = 1'b1;
        end
        ST_DEADON: if (cntZero) begin
          nextState     = ST_DRIVE;
          stb.loadBlank = 1'b1;
          stb.latchDir  = 1'b1;
        end
        ST_DRIVE: if (cntZero && cmpHi) begin
          nextState     = ST_OFF;
          stb.loadOff   = 1'b1;
          stb.latchMode = 1'b1;
        end
        ST_OFF: if (cntZero) begin
          nextState    = ST_DEADON;
          stb.loadDead = 1'b1;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_DRIVE: pattern = dirHeld ? PAT_DIAG1 : PAT_DIAG0;
      ST_OFF: begin
        if (leadDead)      pattern = PAT_NONE;
        else if (slowHeld) pattern = PAT_LOWS;
        else               pattern = dirHeld ? PAT_DIAG0 : PAT_DIAG1;
      end
      default: pattern = PAT_NONE;
    endcase
  end

endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
  import chop_pkg::*;
#(
  parameter int unsigned DEAD_CYC  = 20,
  parameter int unsigned BLANK_CYC = 200,
  parameter int unsigned OFF_CYC   = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic enIn,
  input  logic faultIn,
  input  logic cmpHi,
  input  logic slowDecay,
  input  logic dirIn,
  output logic aHi,
  output logic aLo,
  output logic bHi,
  output logic bLo,
  output logic enPullDown
);
  chopStrobe_t stb;
  logic        cntZero, leadDead, dirHeld, slowHeld;
  logic [3:0]  pattern, gates;
  logic        act;

  assign act        = enIn & ~faultIn;
  assign enPullDown = faultIn;

  chop_datapath #(
    .DEAD_CYC (DEAD_CYC),
    .BLANK_CYC(BLANK_CYC),
    .OFF_CYC  (OFF_CYC)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .dirIn   (dirIn),
    .slowIn  (slowDecay),
    .cntZero (cntZero),
    .leadDead(leadDead),
    .dirHeld (dirHeld),
    .slowHeld(slowHeld)
  );

  chop_control u_ctl (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .cmpHi   (cmpHi),
    .cntZero (cntZero),
    .leadDead(leadDead),
    .dirHeld (dirHeld),
    .slowHeld(slowHeld),
    .stb     (stb),
    .pattern (pattern)
  );

  // shutdown acts within the cycle, ahead of the registered state
  for (genvar g = 0; g < 4; g++) begin : g_mask
    assign gates[g] = pattern[g] & act;
  end

  assign {aHi, aLo, bHi, bLo} = gates;

endmodule

// File: rtl/offtime_chopper_chk.sv
module offtime_chopper_chk (
  input logic clk,
  input logic rst,
  input logic enIn,
  input logic faultIn,
  input logic aHi,
  input logic aLo,
  input logic bHi,
  input logic bLo,
  input logic enPullDown
);
  a_r11_leg_a_excl: assert property (@(posedge clk) disable iff (rst) !(aHi && aLo));
  a_r11_leg_b_excl: assert property (@(posedge clk) disable iff (rst) !(bHi && bLo));

  a_r11_leg_a_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(aHi) || $rose(aLo)) |-> !($past(aHi) || $past(aLo)));
  a_r11_leg_b_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(bHi) || $rose(bLo)) |-> !($past(bHi) || $past(bLo)));

  a_r9_enable_off: assert property (@(posedge clk) disable iff (rst)
    !enIn |-> !(aHi || aLo || bHi || bLo));

  a_r10_fault_off: assert property (@(posedge clk) disable iff (rst)
    faultIn |-> (enPullDown && !(aHi || aLo || bHi || bLo)));

  a_r1_reset_off: assert property (@(posedge clk)
    $past(rst) |-> !(aHi || aLo || bHi || bLo));

endmodule

bind offtime_chopper offtime_chopper_chk u_chk (.*);

// File: tb/offtime_chopper_bench.sv
`timescale 1ns/1ps
module offtime_chopper_bench;
  localparam int DEADC  = 3;
  localparam int BLANKC = 6;
  localparam int OFFC   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enIn = 1'b0, faultIn = 1'b0, cmpHi = 1'b0, slowDecay = 1'b1, dirIn = 1'b0;
  logic aHi, aLo, bHi, bLo, enPullDown;

  int nTests = 0;
  int nFail  = 0;
  int cycles = 0;
  bit running = 1'b0;

  always #2.5 clk = ~clk;

  offtime_chopper #(.DEAD_CYC(DEADC), .BLANK_CYC(BLANKC), .OFF_CYC(OFFC)) u_offtime_chopper (
    .clk(clk), .rst(rst), .enIn(enIn), .faultIn(faultIn), .cmpHi(cmpHi),
    .slowDecay(slowDecay), .dirIn(dirIn),
    .aHi(aHi), .aLo(aLo), .bHi(bHi), .bLo(bLo), .enPullDown(enPullDown)
  );

  // timed reference: phase 0 idle, 1 dead before drive, 2 drive, 3 off
  int   mPhase = 0;
  int   mAge   = 0;
  logic mDir   = 1'b0;
  logic mSlow  = 1'b0;

  always @(posedge clk) begin
    if (rst || !(enIn && !faultIn)) begin
      mPhase = 0; mAge = 0;
    end else begin
      case (mPhase)
        0: begin mPhase = 1; mAge = 0; end
        1: if (mAge == DEADC - 1) begin mPhase = 2; mAge = 0; mDir = dirIn; end
           else mAge++;
        2: if (mAge >= BLANKC - 1 && cmpHi) begin mPhase = 3; mAge = 0; mSlow = slowDecay; end
           else mAge++;
        default: if (mAge == OFFC - 1) begin mPhase = 1; mAge = 0; end
                 else mAge++;
      endcase
    end
  end

  function automatic logic [3:0] expGates();
    logic [3:0] p;
    p = 4'b0000;
    if (mPhase == 2) p = mDir ? 4'b0110 : 4'b1001;
    else if (mPhase == 3 && mAge >= DEADC) p = mSlow ? 4'b0101 : (mDir ? 4'b1001 : 4'b0110);
    if (rst || !enIn || faultIn) p = 4'b0000;
    return p;
  endfunction

  function automatic string phaseTag();
    if (rst) return "R1";
    if (faultIn) return "R10";
    if (!enIn) return "R9";
    case (mPhase)
      0: return "R2";
      1: return "R2";
      2: return (mAge < BLANKC) ? "R4" : "R5";
      default: return (mAge < DEADC) ? "R6" : (mSlow ? "R8" : "R7");
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp, input string what);
    nTests++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (running) begin
      check(phaseTag(), int'({aHi, aLo, bHi, bLo}), int'(expGates()), "gates vs model");
      check("R11", int'((aHi && aLo) || (bHi && bLo)), 0, "leg overlap");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic waitFor(input int ph, input int age);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (mPhase == ph && mAge == age) return;
    end
    check("R6", 0, 1, "wait for phase");
  endtask

  int gap;

  initial begin
    // R1: reset dominates an active enable
    enIn = 1'b1;
    running = 1'b1;
    tick(4);
    check("R1", int'({aHi, aLo, bHi, bLo}), 0, "gates in reset");
    check("R10", int'(enPullDown), 0, "no pull-down without fault");
    rst = 1'b0;

    // R2: startup latency, counted in falling edges until drive
    gap = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #1;
      gap++;
      if ({aHi, aLo, bHi, bLo} != 4'b0000) break;
    end
    check("R2", gap, DEADC + 1, "cycles to first drive");
    check("R3", int'({aHi, aLo, bHi, bLo}), 4'b1001, "drive pattern dir0");

    // R4: comparator pulse inside blanking is ignored
    tick(1);
    cmpHi = 1'b1; tick(2); cmpHi = 1'b0;
    tick(8);
    check("R4", int'({aHi, aLo, bHi, bLo}), 4'b1001, "still driving after blanked pulse");

    // R5, R6, R8: continuous chopping in slow decay
    cmpHi = 1'b1;
    tick(60);
    // R6: measure gap from end of drive to next drive
    waitFor(3, 0);
    gap = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1;
      if ({aHi, aLo, bHi, bLo} == 4'b1001) break;
      gap++;
    end
    check("R6", gap, OFFC + DEADC, "off gap cycles");

    // R7: fast decay, both directions
    slowDecay = 1'b0;
    tick(60);
    dirIn = 1'b1;
    tick(60);

    // R3: direction change during drive has no effect
    cmpHi = 1'b0;
    waitFor(2, 1);
    dirIn = 1'b0;
    tick(1);
    check("R3", int'({aHi, aLo, bHi, bLo}), 4'b0110, "dir held during drive");

    // R12: mode change during recirculation has no effect
    cmpHi = 1'b1;
    slowDecay = 1'b1;
    waitFor(3, DEADC + 1);
    slowDecay = 1'b0;
    tick(1);
    check("R12", int'({aHi, aLo, bHi, bLo}), 4'b0101, "mode held in off");
    tick(40);

    // R9: enable drop mid-drive, then restart
    cmpHi = 1'b0;
    waitFor(2, 2);
    enIn = 1'b0;
    #0.5;
    check("R9", int'({aHi, aLo, bHi, bLo}), 0, "enable low same cycle");
    tick(3);
    enIn = 1'b1;
    tick(20);

    // R10: fault mid-drive
    faultIn = 1'b1;
    #0.5;
    check("R10", int'({aHi, aLo, bHi, bLo}), 0, "fault forces off");
    check("R10", int'(enPullDown), 1, "pull-down asserted");
    tick(5);
    check("R10", int'(enPullDown), 1, "pull-down held");
    faultIn = 1'b0;
    cmpHi = 1'b1;
    tick(60);

    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule